// File: doc/BRIEF.md
# Mode-Driven LED Color and Blink Sequencer

This block turns a mode selector (A, B or C) and a sub-mode number (1 to 6) into grayscale data for a bank of LED groups. Each valid pair selects one fixed 48-bit color word. It can also select a blink rate. The word is the same for every group. It is placed side by side into one wide frame, which a downstream serial writer shifts out. Each time the frame takes a new value, a one-cycle update strobe tells the writer to send it.

Blinking forces the grayscale word to zero for half of each period. Brightness and color-correction settings elsewhere are never touched. The slow blink periods come from a system-clock prescaler followed by a half-period counter. Both are sized from the parameters `CLK_HZ` and `PRESCALE`. When the mode or sub-mode changes, the blink phase restarts in its lit half and the frame is refreshed right away.

Top module: `led_blink_seq`

## Requirements
- R1: Mode codes are 0 = A, 1 = B, 2 = C. For each of these modes, the 48-bit word is {blue[47:32], green[31:16], red[15:0]}, and the sub-mode selects it: 1 = 0000_FFFF_0000, 2 = 0000_0000_FFFF, 3 = FFFF_0000_0000, 4 = 0000_7FFF_FFFF, 5 = FFFF_FFFF_0000, 6 = 0000_FFFF_FFFF (hex).
- R2: Sub-mode 2 blinks at 0.2 Hz in mode A, 1.0 Hz in mode B and 1.5 Hz in mode C. One half-period lasts PRESCALE * ((CLK_HZ/PRESCALE)*5/rate_tenths) cycles, where rate_tenths is the rate in tenths of a hertz (2, 10 or 15).
- R3: Sub-mode 6 blinks at 0.2 Hz in modes A and B and stays steadily lit in mode C.
- R4: All other valid pairs stay steadily lit. While the inputs are held, they produce no update strobe and no frame change.
- R5: A blink period has equal lit and dark halves. In the dark half every frame bit is zero. Each toggle between halves raises `upd_stb` for exactly the cycle in which the new frame appears.
- R6: Group g occupies frame bits [48g+47:48g], and all groups always carry the same word.
- R7: An input change seen at a clock edge takes effect at that edge. The new word appears lit, `upd_stb` pulses, and the next toggle comes one full half-period later.
- R8: Mode code 3, or sub-mode 0 or 7, gives an all-zero frame.
- R9: During reset and afterwards, the frame is zero and `upd_stb` is low until an input differs from mode 3 / sub-mode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_code | input | 2 | Mode selector: 0 = A, 1 = B, 2 = C, 3 = unsupported |
| sub_code | input | 3 | Sub-mode number; 1 to 6 are valid |
| frame_data | output | 48*NUM_GROUPS | Grayscale frame for all groups, group 0 in the low bits |
| upd_stb | output | 1 | One-cycle pulse when the frame takes a new value |

## Verification
The bench sweeps all 32 input codes. A design with a swapped color channel or a mis-decoded code would give a wrong word, or a non-zero frame for an unsupported code. For every blinking pair, the bench counts the exact cycle of each toggle, so an off-by-one in the prescaler or half-period limit shifts a toggle edge and is caught. It holds steady pairs long enough to expose a spurious toggle or strobe. It also switches modes while the dark half is showing: a design that fails to restart would stay dark or toggle early.

// File: rtl/led_seq_pkg.sv
package led_seq_pkg;

   localparam int CH_W   = 16;
   localparam int WORD_W = 3 * CH_W;

   typedef enum logic [1:0] {
      RATE_NONE = 2'd0,
      RATE_02   = 2'd1,
      RATE_10   = 2'd2,
      RATE_15   = 2'd3
   } rate_e;

   localparam logic [CH_W-1:0] CH_OFF  = 16'h0000;
   localparam logic [CH_W-1:0] CH_FULL = 16'hFFFF;
   localparam logic [CH_W-1:0] CH_HALF = 16'h7FFF;

   function automatic logic sel_valid(input logic [1:0] m, input logic [2:0] s);
      return (m != 2'd3) && (s >= 3'd1) && (s <= 3'd6);
   endfunction

   // word layout: {blue, green, red}
   function automatic logic [WORD_W-1:0] color_of(input logic [1:0] m, input logic [2:0] s);
      logic [WORD_W-1:0] w;
      w = '0;
      if (sel_valid(m, s)) begin
         case (s)
            3'd1:    w = {CH_OFF,  CH_FULL, CH_OFF };
            3'd2:    w = {CH_OFF,  CH_OFF,  CH_FULL};
            3'd3:    w = {CH_FULL, CH_OFF,  CH_OFF };
            3'd4:    w = {CH_OFF,  CH_HALF, CH_FULL};
            3'd5:    w = {CH_FULL, CH_FULL, CH_OFF };
            default: w = {CH_OFF,  CH_FULL, CH_FULL};
         endcase
      end
      return w;
   endfunction

   function automatic rate_e rate_of(input logic [1:0] m, input logic [2:0] s);
      rate_e r;
      r = RATE_NONE;
      if (s == 3'd2) begin
         case (m)
            2'd0:    r = RATE_02;
            2'd1:    r = RATE_10;
            2'd2:    r = RATE_15;
            default: r = RATE_NONE;
         endcase
      end else if (s == 3'd6) begin
         if (m == 2'd0 || m == 2'd1) r = RATE_02;
      end
      return r;
   endfunction

endpackage

// File: rtl/led_seq_lut.sv
module led_seq_lut
   import led_seq_pkg::*;
(
   input  logic [1:0]        mode_sel,
   input  logic [2:0]        sub_sel,
   output logic [WORD_W-1:0] color,
   output rate_e             rate
);

   always_comb begin
      color = color_of(mode_sel, sub_sel);
      rate  = rate_of(mode_sel, sub_sel);
   end

endmodule

// File: rtl/led_seq_timer.sv
module led_seq_timer
   import led_seq_pkg::*;
#(
   parameter int PRESCALE = 1000,
   parameter int HALF_02  = 250000,
   parameter int HALF_10  = 50000,
   parameter int HALF_15  = 33333
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  restart,
   input  rate_e rate,
   output logic  phase_on,
   output logic  toggle
);

   localparam int HW = $clog2(HALF_02 + 1);
   localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
   localparam logic [HW-1:0] LIM_02 = HW'(HALF_02 - 1);
   localparam logic [HW-1:0] LIM_10 = HW'(HALF_10 - 1);
   localparam logic [HW-1:0] LIM_15 = HW'(HALF_15 - 1);

   logic          tick;
   logic          blinking;
   logic [HW-1:0] half_lim;
   logic [HW-1:0] half_cnt;
   logic          at_lim;

   generate
      if (PRESCALE == 1) begin : g_no_div
         assign tick = 1'b1;
      end else begin : g_div
         logic [PW-1:0] pre_cnt;
         always_ff @(posedge clk) begin
            if (!rst_n || restart)                  pre_cnt <= '0;
            else if (pre_cnt == PW'(PRESCALE - 1))  pre_cnt <= '0;
            else                                    pre_cnt <= pre_cnt + 1'b1;
         end
         assign tick = (pre_cnt == PW'(PRESCALE - 1));
      end
   endgenerate

   always_comb begin
      case (rate)
         RATE_02: half_lim = LIM_02;
         RATE_10: half_lim = LIM_10;
         RATE_15: half_lim = LIM_15;
         default: half_lim = '0;
      endcase
   end

   assign blinking = (rate != RATE_NONE);
   assign at_lim   = (half_cnt == half_lim);
   assign toggle   = blinking && !restart && tick && at_lim;

   always_ff @(posedge clk) begin
      if (!rst_n || restart || !blinking) begin
         half_cnt <= '0;
         phase_on <= 1'b1;
      end else if (tick) begin
         if (at_lim) begin
            half_cnt <= '0;
            phase_on <= ~phase_on;
         end else begin
            half_cnt <= half_cnt + 1'b1;
         end
      end
   end

endmodule

// File: rtl/led_seq_frame.sv
module led_seq_frame
   import led_seq_pkg::*;
#(
   parameter int NUM_GROUPS = 16
) (
   input  logic [WORD_W-1:0]            color,
   input  logic                         phase_on,
   output logic [NUM_GROUPS*WORD_W-1:0] frame
);

   logic [WORD_W-1:0] word;

   assign word = phase_on ? color : '0;

   generate
      for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
         assign frame[g*WORD_W +: WORD_W] = word;
      end
   endgenerate

endmodule

// File: rtl/led_blink_seq.sv
module led_blink_seq
   import led_seq_pkg::*;
#(
   parameter int CLK_HZ     = 100_000_000,
   parameter int PRESCALE   = 1000,
   parameter int NUM_GROUPS = 16
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [1:0]                   mode_code,
   input  logic [2:0]                   sub_code,
   output logic [NUM_GROUPS*WORD_W-1:0] frame_data,
   output logic                         upd_stb
);

   localparam int TICK_HZ = CLK_HZ / PRESCALE;
   localparam int HALF_02 = TICK_HZ * 5 / 2;
   localparam int HALF_10 = TICK_HZ * 5 / 10;
   localparam int HALF_15 = TICK_HZ * 5 / 15;

   generate
      if (PRESCALE < 1)              $error("PRESCALE must be at least 1");
      if (CLK_HZ % PRESCALE != 0)    $error("CLK_HZ must be a multiple of PRESCALE");
      if (HALF_15 < 1)               $error("tick rate too low for the fastest blink");
      if (NUM_GROUPS < 1)            $error("NUM_GROUPS must be at least 1");
   endgenerate

   logic [4:0]        sel_q;
   logic              chg;
   logic [WORD_W-1:0] color;
   rate_e             rate;
   logic              phase_on;
   logic              toggle;

   assign chg = ({mode_code, sub_code} != sel_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel_q   <= {2'd3, 3'd0};
         upd_stb <= 1'b0;
      end else begin
         sel_q   <= {mode_code, sub_code};
         upd_stb <= chg || toggle;
      end
   end

   led_seq_lut u_lut (
      .mode_sel (sel_q[4:3]),
      .sub_sel  (sel_q[2:0]),
      .color    (color),
      .rate     (rate)
   );

   led_seq_timer #(
      .PRESCALE (PRESCALE),
      .HALF_02  (HALF_02),
      .HALF_10  (HALF_10),
      .HALF_15  (HALF_15)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .restart  (chg),
      .rate     (rate),
      .phase_on (phase_on),
      .toggle   (toggle)
   );

   led_seq_frame #(
      .NUM_GROUPS (NUM_GROUPS)
   ) u_frame (
      .color    (color),
      .phase_on (phase_on),
      .frame    (frame_data)
   );

endmodule

// File: rtl/led_blink_seq_chk.sv
module led_blink_seq_chk
   import led_seq_pkg::*;
#(
   parameter int NUM_GROUPS = 16
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic [1:0]                   mode_code,
   input logic [2:0]                   sub_code,
   input logic [4:0]                   sel_q,
   input logic                         phase_on,
   input logic [NUM_GROUPS*WORD_W-1:0] frame_data,
   input logic                         upd_stb
);

   logic [4:0] sel_in;
   assign sel_in = {mode_code, sub_code};

   assert_restart_lit_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_in != sel_q) |=> (upd_stb && phase_on && sel_q == $past(sel_in)));

   assert_groups_equal_R6: assert property (@(posedge clk) disable iff (!rst_n)
      frame_data[WORD_W-1:0] == frame_data[NUM_GROUPS*WORD_W-1 -: WORD_W]);

   assert_invalid_dark_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_valid(sel_q[4:3], sel_q[2:0]) |-> (frame_data == '0));

   assert_dark_half_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !phase_on |-> (frame_data == '0));

   assert_steady_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_in == sel_q && rate_of(sel_q[4:3], sel_q[2:0]) == RATE_NONE)
      |=> (!upd_stb && $stable(frame_data)));

   assert_strobe_on_toggle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_stb && $past(sel_in == sel_q)) |-> (phase_on != $past(phase_on)));

endmodule

bind led_blink_seq led_blink_seq_chk #(.NUM_GROUPS(NUM_GROUPS)) i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .mode_code  (mode_code),
   .sub_code   (sub_code),
   .sel_q      (sel_q),
   .phase_on   (phase_on),
   .frame_data (frame_data),
   .upd_stb    (upd_stb)
);

// File: tb/test_led_blink_seq.sv
module test_led_blink_seq;

   localparam int CLK_HZ   = 3000;
   localparam int PRESCALE = 10;
   localparam int NG       = 16;
   localparam int WW       = 48;
   localparam int TICK_HZ  = CLK_HZ / PRESCALE;
   localparam int HP_02    = PRESCALE * (TICK_HZ * 5 / 2);
   localparam int HP_10    = PRESCALE * (TICK_HZ * 5 / 10);
   localparam int HP_15    = PRESCALE * (TICK_HZ * 5 / 15);

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [1:0]        mode_code = 2'd3;
   logic [2:0]        sub_code = 3'd0;
   logic [NG*WW-1:0]  frame_data;
   logic              upd_stb;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   led_blink_seq #(
      .CLK_HZ     (CLK_HZ),
      .PRESCALE   (PRESCALE),
      .NUM_GROUPS (NG)
   ) i_led_blink_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .mode_code  (mode_code),
      .sub_code   (sub_code),
      .frame_data (frame_data),
      .upd_stb    (upd_stb)
   );

   function automatic logic [WW-1:0] exp_word(input int m, input int s);
      logic [15:0] b, g, r;
      if (m > 2 || s < 1 || s > 6) return '0;
      b = 16'h0; g = 16'h0; r = 16'h0;
      case (s)
         1: g = 16'hFFFF;
         2: r = 16'hFFFF;
         3: b = 16'hFFFF;
         4: begin g = 16'h7FFF; r = 16'hFFFF; end
         5: begin b = 16'hFFFF; g = 16'hFFFF; end
         default: begin g = 16'hFFFF; r = 16'hFFFF; end
      endcase
      return {b, g, r};
   endfunction

   task automatic chk(input bit ok, input string req, input logic [WW-1:0] act, input logic [WW-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // R6: every group must carry the expected word
   task automatic chk_frame(input string req, input logic [WW-1:0] exp);
      logic [WW-1:0] act;
      bit ok;
      ok = 1'b1;
      act = frame_data[WW-1:0];
      for (int g = 0; g < NG; g++) begin
         if (frame_data[g*WW +: WW] != exp) begin
            ok = 1'b0;
            act = frame_data[g*WW +: WW];
         end
      end
      chk(ok, req, act, exp);
   endtask

   task automatic chk_stb(input string req, input logic exp);
      chk(upd_stb == exp, req, {47'd0, upd_stb}, {47'd0, exp});
   endtask

   task automatic apply(input int m, input int s);
      @(negedge clk);
      mode_code = 2'(m);
      sub_code  = 3'(s);
      @(negedge clk);
   endtask

   task automatic blink_test(input int m, input int s, input int hp, input string req);
      logic [WW-1:0] w;
      w = exp_word(m, s);
      apply(m, s);
      chk_frame({req, " lit after select"}, w);
      chk_stb({req, " strobe on select"}, 1'b1);
      repeat (hp - 1) @(negedge clk);
      chk_frame({req, " still lit before half"}, w);
      chk_stb({req, " no early strobe"}, 1'b0);
      @(negedge clk);
      chk_frame({req, " R5 dark half"}, '0);
      chk_stb({req, " R5 strobe at dark"}, 1'b1);
      repeat (hp - 1) @(negedge clk);
      chk_frame({req, " R5 still dark"}, '0);
      @(negedge clk);
      chk_frame({req, " R5 lit again"}, w);
      chk_stb({req, " R5 strobe at lit"}, 1'b1);
   endtask

   task automatic steady_test(input int m, input int s, input string req);
      int strobes;
      bit changed;
      logic [WW-1:0] w;
      w = exp_word(m, s);
      apply(m, s);
      chk_frame({req, " steady lit"}, w);
      strobes = 0;
      changed = 1'b0;
      for (int i = 0; i < HP_02 + 500; i++) begin
         @(negedge clk);
         if (upd_stb) strobes++;
         if (frame_data[WW-1:0] != w) changed = 1'b1;
      end
      chk(strobes == 0, {req, " no strobe while held"}, 48'(strobes), 48'd0);
      chk(!changed, {req, " frame held"}, frame_data[WW-1:0], w);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      // R9 reset state
      repeat (3) @(negedge clk);
      chk_frame("R9 frame zero in reset", '0);
      chk_stb("R9 strobe low in reset", 1'b0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk_frame("R9 frame zero after reset", '0);
      chk_stb("R9 no strobe after reset", 1'b0);

      // R1 and R8: sweep of all input codes
      for (int m = 0; m < 4; m++) begin
         for (int s = 0; s < 8; s++) begin
            apply(m, s);
            chk_frame((m > 2 || s == 0 || s == 7) ? "R8 unsupported code zero" : "R1 color word", exp_word(m, s));
            chk_stb("R7 strobe on code change", 1'b1);
         end
      end

      // R2 sub-mode 2 rates, R3 sub-mode 6 rates
      blink_test(0, 2, HP_02, "R2 A/2");
      blink_test(1, 2, HP_10, "R2 B/2");
      blink_test(2, 2, HP_15, "R2 C/2");
      blink_test(0, 6, HP_02, "R3 A/6");
      blink_test(1, 6, HP_02, "R3 B/6");
      steady_test(2, 6, "R3 C/6");
      steady_test(0, 4, "R4 A/4");

      // R7 restart while dark
      apply(1, 2);
      repeat (HP_10) @(negedge clk);
      chk_frame("R7 setup dark", '0);
      apply(0, 2);
      chk_frame("R7 lit at once after change", exp_word(0, 2));
      chk_stb("R7 strobe on change", 1'b1);
      repeat (HP_02 - 1) @(negedge clk);
      chk_frame("R7 full half before toggle", exp_word(0, 2));
      @(negedge clk);
      chk_frame("R7 toggle after full half", '0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule